// File: doc/BRIEF.md
# Left-Indexed Vector Element Extractor

This unit pulls one unsigned element of 1, 2 or 4 bytes out of a 128-bit vector operand and returns it as a zero-extended 64-bit scalar for a general-purpose register. The start byte comes from a run-time scalar operand, not from an immediate. Only its low four bits count. Bytes are numbered from the most significant end of the vector. The element is assembled with the start byte in its most significant position.

An element may start at any byte, so it can sit wholly in the upper 64-bit half, wholly in the lower half, or straddle the two. It can also run past the last byte. Byte positions past 15 read as zero.

The unit decodes its three operations from a group code and a sub-code. It hands the shared word sub-code to another unit when the newer-ISA mode is off. It reports a vector-unavailable flag when the vector facility is disabled, and an illegal-op flag for codes it does not know. Every outcome appears one clock after the input strobe.

Top module: `vec_extract_left`

## Requirements
- R1: Only offsetIn[3:0] selects the start byte (0 to 15); offsetIn[63:4] has no effect on the result.
- R2: Byte k of the vector is vecIn[127-8k -: 8], so byte 0 is bits 127:120. The byte at the start index lands in the most significant byte of the element, followed by start+1, and so on.
- R3: With grpCode 6, subCode 24 extracts 1 byte and subCode 25 extracts 2 bytes. subCode 26 extracts 4 bytes when isaNew is 1. The result is zero-extended to 64 bits.
- R4: Any element byte whose position would exceed 15 reads as zero; a 4-byte extract at offset 14 gives bytes 14, 15, 0x00, 0x00.
- R5: Elements wholly in the upper half, wholly in the lower half, or straddling the boundary between bytes 7 and 8 are all returned correctly.
- R6: grpCode 6 with subCode 26 and isaNew 0 is not handled here: outValid, vecUnavail and illegalOp all stay 0 and result stays 0.
- R7: A handled extract with vecEn 0 sets vecUnavail for one cycle, with outValid 0 and result 0.
- R8: Any other grpCode, or grpCode 6 with a subCode other than 24, 25 or 26, sets illegalOp for one cycle with result 0. This holds regardless of vecEn.
- R9: Outputs are registered: they reflect the input sampled with inValid on the previous rising edge. With no strobe they are all 0, and synchronous active-high rst clears them.
- R10: At most one of outValid, vecUnavail and illegalOp is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation strobe |
| grpCode | input | 5 | Group opcode field (6 selects this unit's family) |
| subCode | input | 5 | Secondary opcode field |
| isaNew | input | 1 | Newer ISA level: sub-code 26 is the word extract |
| vecEn | input | 1 | Vector facility enable |
| offsetIn | input | 64 | Scalar start-byte operand |
| vecIn | input | 128 | Vector operand |
| outValid | output | 1 | Result strobe |
| result | output | 64 | Zero-extended element |
| vecUnavail | output | 1 | Vector-unavailable exception flag |
| illegalOp | output | 1 | Unrecognised-opcode flag |

## Verification
A wrong shift amount or a bad window width shows up at result one cycle after the strobe. It takes the form of shifted or missing bytes, most often at offsets near the half boundary and near byte 15. A decode fault shows in that same cycle as the wrong flag or a flag pair. It also shows as a result that is not zero while outValid is low. The random operands use mostly real codes and offsets with random high bits. Together with directed cases at offsets 0, 7, 14 and 15, they expose each of these within a few operations.

// File: rtl/vxl_pkg.sv
package vxl_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } elemSz_e;

  typedef struct packed {
    logic    load;
    logic    unavail;
    logic    illegal;
    elemSz_e size;
  } ctrlStrb_t;

  localparam int unsigned GRP_VX   = 6;
  localparam int unsigned SUB_BYTE = 24;
  localparam int unsigned SUB_HALF = 25;
  localparam int unsigned SUB_WORD = 26;
endpackage

// File: rtl/vxl_ctrl.sv
module vxl_ctrl
  import vxl_pkg::*;
#(
  parameter int GRP_W = 5,
  parameter int SUB_W = 5
) (
  input  logic             inValid,
  input  logic [GRP_W-1:0] grpCode,
  input  logic [SUB_W-1:0] subCode,
  input  logic             isaNew,
  input  logic             vecEn,
  output ctrlStrb_t        strb
);
  logic isOurs;

  always_comb begin
    strb   = '0;
    isOurs = 1'b0;
    if (inValid) begin
      if (grpCode == GRP_W'(GRP_VX)) begin
        case (subCode)
          SUB_W'(SUB_BYTE): begin isOurs = 1'b1; strb.size = SZ_BYTE; end
          SUB_W'(SUB_HALF): begin isOurs = 1'b1; strb.size = SZ_HALF; end
          SUB_W'(SUB_WORD): begin
            // shared code: only ours at the newer ISA level
            isOurs    = isaNew;
            strb.size = SZ_WORD;
          end
          default: strb.illegal = 1'b1;
        endcase
      end else begin
        strb.illegal = 1'b1;
      end
      if (isOurs) begin
        strb.load    = vecEn;
        strb.unavail = ~vecEn;
      end
    end
  end
endmodule

// File: rtl/vxl_dpath.sv
module vxl_dpath
  import vxl_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int RES_W = 64,
  parameter int OFF_W = 64,
  parameter int MAX_B = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrb_t        strb,
  input  logic [OFF_W-1:0] offsetIn,
  input  logic [VEC_W-1:0] vecIn,
  output logic             outValid,
  output logic [RES_W-1:0] result,
  output logic             vecUnavail,
  output logic             illegalOp
);
  localparam int IDX_W = $clog2(VEC_W / 8);
  localparam int WIN_W = MAX_B * 8;
  localparam int PAD_W = VEC_W + WIN_W;
  localparam int N_SZ  = $clog2(MAX_B) + 1;

  logic [IDX_W-1:0] startIdx;
  logic [PAD_W-1:0] padded;
  logic [PAD_W-1:0] shifted;
  logic [WIN_W-1:0] window;
  logic [RES_W-1:0] cand [N_SZ];
  logic [RES_W-1:0] elemVal;

  // zero padding below the vector supplies the bytes past the end
  assign startIdx = offsetIn[IDX_W-1:0];
  assign padded   = {vecIn, {WIN_W{1'b0}}};
  assign shifted  = padded << {startIdx, 3'b000};
  assign window   = shifted[PAD_W-1 -: WIN_W];

  for (genvar s = 0; s < N_SZ; s++) begin : g_size
    localparam int NB = 1 << s;
    assign cand[s] = RES_W'(window[WIN_W-1 -: NB*8]);
  end

  always_comb begin
    case (strb.size)
      SZ_BYTE: elemVal = cand[0];
      SZ_HALF: elemVal = cand[1];
      default: elemVal = cand[2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid   <= 1'b0;
      vecUnavail <= 1'b0;
      illegalOp  <= 1'b0;
      result     <= '0;
    end else begin
      outValid   <= strb.load;
      vecUnavail <= strb.unavail;
      illegalOp  <= strb.illegal;
      result     <= strb.load ? elemVal : '0;
    end
  end
endmodule

// File: rtl/vec_extract_left.sv
module vec_extract_left
  import vxl_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int RES_W = 64,
  parameter int OFF_W = 64,
  parameter int GRP_W = 5,
  parameter int SUB_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [GRP_W-1:0] grpCode,
  input  logic [SUB_W-1:0] subCode,
  input  logic             isaNew,
  input  logic             vecEn,
  input  logic [OFF_W-1:0] offsetIn,
  input  logic [VEC_W-1:0] vecIn,
  output logic             outValid,
  output logic [RES_W-1:0] result,
  output logic             vecUnavail,
  output logic             illegalOp
);
  ctrlStrb_t strb;

  vxl_ctrl #(.GRP_W(GRP_W), .SUB_W(SUB_W)) u_ctrl (
    .inValid(inValid), .grpCode(grpCode), .subCode(subCode),
    .isaNew(isaNew), .vecEn(vecEn), .strb(strb)
  );

  vxl_dpath #(.VEC_W(VEC_W), .RES_W(RES_W), .OFF_W(OFF_W), .MAX_B(4)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .offsetIn(offsetIn), .vecIn(vecIn),
    .outValid(outValid), .result(result), .vecUnavail(vecUnavail),
    .illegalOp(illegalOp)
  );
endmodule

// File: rtl/vxl_checker.sv
module vxl_checker #(
  parameter int VEC_W = 128,
  parameter int RES_W = 64,
  parameter int OFF_W = 64,
  parameter int GRP_W = 5,
  parameter int SUB_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [GRP_W-1:0] grpCode,
  input logic [SUB_W-1:0] subCode,
  input logic             isaNew,
  input logic             vecEn,
  input logic [OFF_W-1:0] offsetIn,
  input logic [VEC_W-1:0] vecIn,
  input logic             outValid,
  input logic [RES_W-1:0] result,
  input logic             vecUnavail,
  input logic             illegalOp
);
  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({outValid, vecUnavail, illegalOp}));

  assert_needs_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    (outValid || vecUnavail || illegalOp) |-> $past(inValid));

  assert_zero_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> (result == '0));

  assert_unavail_cause_R7: assert property (@(posedge clk) disable iff (rst)
    vecUnavail |-> !$past(vecEn));

  assert_byte_width_R3: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(subCode) == SUB_W'(24)) |-> (result[RES_W-1:8] == '0));

  assert_word_width_R3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (result[RES_W-1:32] == '0));

  assert_bad_group_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(inValid) && $past(grpCode) != GRP_W'(6)) |-> illegalOp);

  assert_shared_code_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(inValid) && $past(grpCode) == GRP_W'(6) && $past(subCode) == SUB_W'(26)
     && !$past(isaNew)) |-> !(outValid || vecUnavail || illegalOp));
endmodule

bind vec_extract_left vxl_checker #(
  .VEC_W(VEC_W), .RES_W(RES_W), .OFF_W(OFF_W), .GRP_W(GRP_W), .SUB_W(SUB_W)
) u_chk (.*);

// File: tb/tb_vec_extract_left.sv
module tb_vec_extract_left;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [4:0]   grpCode = '0;
  logic [4:0]   subCode = '0;
  logic         isaNew = 1'b0;
  logic         vecEn = 1'b0;
  logic [63:0]  offsetIn = '0;
  logic [127:0] vecIn = '0;
  logic         outValid;
  logic [63:0]  result;
  logic         vecUnavail;
  logic         illegalOp;

  int checks = 0;
  int fails  = 0;

  localparam logic [127:0] PAT = 128'h00112233_44556677_8899AABB_CCDDEEFF;

  always #4 clk = ~clk;

  vec_extract_left dut (.*);

  task automatic model(input logic v, input logic [4:0] g, s, input logic isa, en,
                       input logic [63:0] off, input logic [127:0] vec,
                       output logic ev, output logic [63:0] er, output logic eu, ei);
    int n = 0;
    int idx;
    ev = 0; er = '0; eu = 0; ei = 0;
    if (v) begin
      if (g != 5'd6) ei = 1;
      else case (s)
        5'd24: n = 1;
        5'd25: n = 2;
        5'd26: n = isa ? 4 : 0;
        default: ei = 1;
      endcase
      if (n != 0) begin
        if (en) begin
          ev = 1;
          idx = int'(off[3:0]);
          for (int j = 0; j < n; j++) begin
            er = er << 8;
            if (idx + j <= 15) er[7:0] = vec[127 - 8*(idx + j) -: 8];
          end
        end else eu = 1;
      end
    end
  endtask

  task automatic compare(input string tag, input logic ev, input logic [63:0] er,
                         input logic eu, ei);
    checks++;
    if (outValid !== ev || result !== er || vecUnavail !== eu || illegalOp !== ei) begin
      fails++;
      $display("FAIL %s: got v=%0b r=%h u=%0b i=%0b, expected v=%0b r=%h u=%0b i=%0b",
               tag, outValid, result, vecUnavail, illegalOp, ev, er, eu, ei);
    end
  endtask

  task automatic apply(input string tag, input logic v, input logic [4:0] g, s,
                       input logic isa, en, input logic [63:0] off, input logic [127:0] vec);
    logic ev, eu, ei;
    logic [63:0] er;
    @(negedge clk);
    inValid = v; grpCode = g; subCode = s; isaNew = isa; vecEn = en;
    offsetIn = off; vecIn = vec;
    model(v, g, s, isa, en, off, vec, ev, er, eu, ei);
    @(negedge clk);
    compare(tag, ev, er, eu, ei);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20161123));
    repeat (3) @(negedge clk);
    compare("R9 reset state", 0, '0, 0, 0);
    rst = 1'b0;

    apply("R2 byte at 0",          1, 6, 24, 1, 1, 64'd0,  PAT);
    apply("R2 half at 0",          1, 6, 25, 1, 1, 64'd0,  PAT);
    apply("R5 word upper half",    1, 6, 26, 1, 1, 64'd2,  PAT);
    apply("R5 word straddle",      1, 6, 26, 1, 1, 64'd6,  PAT);
    apply("R5 half straddle",      1, 6, 25, 1, 1, 64'd7,  PAT);
    apply("R5 word lower half",    1, 6, 26, 1, 1, 64'd9,  PAT);
    apply("R4 word at 14",         1, 6, 26, 1, 1, 64'd14, PAT);
    apply("R4 half at 15",         1, 6, 25, 1, 1, 64'd15, PAT);
    apply("R1 high offset bits",   1, 6, 26, 1, 1, 64'hFFFF_0000_0000_0053, PAT);
    apply("R3 byte zero-extend",   1, 6, 24, 0, 1, 64'd15, PAT);
    apply("R6 shared code",        1, 6, 26, 0, 1, 64'd3,  PAT);
    apply("R7 facility off",       1, 6, 25, 1, 0, 64'd4,  PAT);
    apply("R8 bad sub",            1, 6, 27, 1, 1, 64'd0,  PAT);
    apply("R8 bad group",          1, 4, 24, 1, 0, 64'd0,  PAT);
    apply("R9 no strobe",          0, 6, 24, 1, 1, 64'd1,  PAT);

    for (int k = 0; k < 400; k++) begin
      logic [4:0] g, s;
      logic [127:0] vec;
      g = ($urandom % 8 == 0) ? 5'($urandom) : 5'd6;
      s = ($urandom % 8 == 0) ? 5'($urandom) : 5'(24 + $urandom % 3);
      vec = {$urandom, $urandom, $urandom, $urandom};
      apply("R10 random", ($urandom % 10) != 0, g, s, 1'($urandom), ($urandom % 6) != 0,
            {$urandom, $urandom}, vec);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule